// File: doc/BRIEF.md
# Descriptor Queue Manager

This block holds descriptor addresses in a set of independent hardware queues and is driven through a register window mapped into memory. Every queue owns four 32-bit word slots: a live entry count, a running byte total, a per-packet control word, and a descriptor word. An access to the descriptor word performs the queue operation. A write pushes the written address, and a read pops the descriptor at the head and returns it. The three words before it are optional steps of the same access sequence. They carry a packet size and a head/tail selector on a push, and on a pop they return the count, the byte total and the size of the head packet.

One staging register set serves every queue. The queue is taken from the address bits above the 16-byte stride. A sequence is a run of accesses to one queue, in one direction, at rising word offsets. If a sequence is broken before its descriptor word arrives, the pending operation still runs. A broken write pushes the staged values, with descriptor 0 by default. A broken read removes the head and discards it. Storage is a single pool of linked-list nodes that all queues share, with a free list. When the pool is full, a push is dropped and a sticky overflow pin is raised.

The request channel is valid/ready. `req_ready` stays high except during the single cycle in which an implied operation from a broken sequence runs. In that cycle the new request is held and is accepted on the next cycle. Reads have no back-pressure on the response: `rsp_valid` pulses for one cycle, exactly one cycle after each accepted read.

Top module: `dq_manager`

## Requirements
- R1: The byte address selects queue `addr[QW+3:4]` and word `addr[3:2]`. Word 0 is the count, 1 the byte total, 2 the control word and 3 the descriptor word. Each queue spans 16 bytes.
- R2: A read of word 0 returns the number of descriptors currently held in the addressed queue.
- R3: A read of word 1 returns the sum of the packet sizes of all descriptors currently in the addressed queue.
- R4: A write of word 2 stages bit 31 as the head select (1 = push at head) and bits [15:0] as the packet size. These apply to the push that ends the sequence. All staging is cleared after every push or pop.
- R5: A write of word 3 pushes the written address. With head select 0 the queues are first-in first-out; with head select 1 the new descriptor is popped next.
- R6: A read of word 2 returns the packet size of the head descriptor, or 0 when the queue is empty. A read of word 3 returns the head address and removes it.
- R7: A pop from an empty queue returns 0 and leaves the count and the byte total at 0.
- R8: A push while all NODES pool entries are in use is dropped, and the queue is left unchanged. `ovf_flag` then rises and stays high until reset.
- R9: A write sequence broken by any non-continuing access still pushes, using the staged size and descriptor 0. `req_ready` is low for exactly that one cycle.
- R10: A read sequence broken before word 3 still removes the head descriptor of its queue.
- R11: Write data to words 0 and 1 is ignored. Such a write only opens a push sequence.
- R12: After reset `req_ready` is 1 and `rsp_valid` is 0. Each accepted read gives `rsp_valid` one cycle later.
- R13: Pool entries freed by pops are reused, so the queues together can again hold NODES descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW-2 | Byte address bits [AW-1:2] of the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_data | output | 32 | Read data |
| ovf_flag | output | 1 | Sticky pool-overflow status |

## Verification
The main function is tested with three orderings: tail pushes drained in order, a head push mixed into earlier tail pushes, and one queue filled to the pool limit and then drained. These show first-in first-out order, last-in first-out override, and recycling through the free list. Broken sequences are driven in three ways: a read broken by a write of another word, a read broken by an access to another queue, and a write broken by a write to another queue. These separate an implied pop, an implied push carrying only staged data, and the one-cycle stall. The byte totals and head sizes read back show whether the staged size actually reached the pushed node.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  // Word slot inside one queue's 16-byte window; the order defines the sequence rule
  typedef enum logic [1:0] {
    W_COUNT = 2'd0,
    W_BYTES = 2'd1,
    W_CTRL  = 2'd2,
    W_DESC  = 2'd3
  } word_e;

  localparam int HEAD_SEL_BIT = 31;
endpackage

// File: rtl/qm_mailbox.sv
module qm_mailbox
  import dqm_pkg::*;
#(
  parameter int QW     = 3,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [QW-1:0]     req_q,
  input  word_e             req_word,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              op_push,
  output logic              op_pop,
  output logic [QW-1:0]     op_q,
  output logic [31:0]       op_desc,
  output logic [SIZE_W-1:0] op_size,
  output logic              op_head
);
  logic              pend_v, pend_wr;
  logic [QW-1:0]     pend_q;
  word_e             pend_word;
  logic [SIZE_W-1:0] stg_size;
  logic              stg_head;
  logic              cont, implied, acc, fin;

  // a request continues the open sequence only on same queue, same direction, later word
  assign cont      = pend_v && (req_q == pend_q) && (req_write == pend_wr) && (req_word > pend_word);
  assign implied   = pend_v && req_valid && !cont;
  assign req_ready = !implied;
  assign acc       = req_valid && req_ready;
  assign fin       = acc && (req_word == W_DESC);

  assign op_push = implied ? pend_wr  : (fin && req_write);
  assign op_pop  = implied ? !pend_wr : (fin && !req_write);
  assign op_q    = implied ? pend_q   : req_q;
  assign op_desc = implied ? 32'd0    : req_wdata;
  assign op_size = stg_size;
  assign op_head = stg_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_wr   <= 1'b0;
      pend_q    <= '0;
      pend_word <= W_COUNT;
      stg_size  <= '0;
      stg_head  <= 1'b0;
    end else if (implied || fin) begin
      pend_v   <= 1'b0;
      stg_size <= '0;
      stg_head <= 1'b0;
    end else if (acc) begin
      pend_v    <= 1'b1;
      pend_wr   <= req_write;
      pend_q    <= req_q;
      pend_word <= req_word;
      if (req_write && req_word == W_CTRL) begin
        stg_size <= req_wdata[SIZE_W-1:0];
        stg_head <= req_wdata[HEAD_SEL_BIT];
      end
    end
  end

  // R12: a stall lasts a single cycle
  p_stall_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  // R9: once an operation has run, no sequence is left open
  p_seq_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_push || op_pop) |=> !pend_v);
  // R4: staging is empty right after any operation
  p_stage_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_push || op_pop) |=> (stg_size == '0 && !stg_head));
endmodule

// File: rtl/qm_store.sv
module qm_store #(
  parameter int NODES  = 16,
  parameter int SIZE_W = 16,
  parameter int PW     = $clog2(NODES),
  parameter int CW     = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_push,
  input  logic              link_tail,
  input  logic [PW-1:0]     tail_node,
  input  logic              link_head,
  input  logic [PW-1:0]     head_node,
  input  logic [31:0]       desc,
  input  logic [SIZE_W-1:0] size,
  input  logic              do_pop,
  input  logic [PW-1:0]     pop_node,
  input  logic [PW-1:0]     peek_node,
  output logic              push_ok,
  output logic [PW-1:0]     new_node,
  output logic [PW-1:0]     pop_next,
  output logic [SIZE_W-1:0] pop_size,
  output logic [31:0]       peek_desc,
  output logic [SIZE_W-1:0] peek_size,
  output logic              ovf
);
  logic [PW-1:0]     nxt [NODES];
  logic [31:0]       dsc [NODES];
  logic [SIZE_W-1:0] siz [NODES];
  logic [PW-1:0]     free_hd;
  logic [CW-1:0]     free_cnt;
  logic              full;

  assign full      = (free_cnt == '0);
  assign push_ok   = do_push && !full;
  assign new_node  = free_hd;
  assign pop_next  = nxt[pop_node];
  assign pop_size  = siz[pop_node];
  assign peek_desc = dsc[peek_node];
  assign peek_size = siz[peek_node];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) nxt[i] <= PW'(i + 1);
      free_hd  <= '0;
      free_cnt <= CW'(NODES);
      ovf      <= 1'b0;
    end else begin
      if (do_push && full) ovf <= 1'b1;
      if (push_ok) begin
        free_hd  <= nxt[free_hd];
        free_cnt <= free_cnt - 1'b1;
        if (link_tail) nxt[tail_node] <= free_hd;
        if (link_head) nxt[free_hd]   <= head_node;
      end else if (do_pop) begin
        nxt[pop_node] <= free_hd;
        free_hd       <= pop_node;
        free_cnt      <= free_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      dsc[free_hd] <= desc;
      siz[free_hd] <= size;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && full) |=> ovf);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_free_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(NODES));
endmodule

// File: rtl/qm_qstate.sv
module qm_qstate #(
  parameter int NQ      = 8,
  parameter int NODES   = 16,
  parameter int SIZE_W  = 16,
  parameter int BYTES_W = 24,
  parameter int QW      = $clog2(NQ),
  parameter int PW      = $clog2(NODES),
  parameter int CW      = $clog2(NODES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QW-1:0]      op_q,
  input  logic               push_ok,
  input  logic               push_head,
  input  logic [PW-1:0]      new_node,
  input  logic [SIZE_W-1:0]  push_size,
  input  logic               pop_req,
  input  logic [PW-1:0]      pop_next,
  input  logic [SIZE_W-1:0]  pop_size,
  input  logic [QW-1:0]      sel_q,
  output logic               op_empty,
  output logic [PW-1:0]      op_head_node,
  output logic [PW-1:0]      op_tail_node,
  output logic [CW-1:0]      sel_cnt,
  output logic [BYTES_W-1:0] sel_bytes,
  output logic [PW-1:0]      sel_head_node,
  output logic               sel_empty
);
  logic [PW-1:0]      hd  [NQ];
  logic [PW-1:0]      tl  [NQ];
  logic [CW-1:0]      cnt [NQ];
  logic [BYTES_W-1:0] byt [NQ];
  logic               pop_ok;

  assign op_empty      = (cnt[op_q] == '0);
  assign op_head_node  = hd[op_q];
  assign op_tail_node  = tl[op_q];
  assign sel_cnt       = cnt[sel_q];
  assign sel_bytes     = byt[sel_q];
  assign sel_head_node = hd[sel_q];
  assign sel_empty     = (cnt[sel_q] == '0);
  assign pop_ok        = pop_req && !op_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        hd[i]  <= '0;
        tl[i]  <= '0;
        cnt[i] <= '0;
        byt[i] <= '0;
      end
    end else if (push_ok) begin
      if (op_empty) begin
        hd[op_q] <= new_node;
        tl[op_q] <= new_node;
      end else if (push_head) begin
        hd[op_q] <= new_node;
      end else begin
        tl[op_q] <= new_node;
      end
      cnt[op_q] <= cnt[op_q] + 1'b1;
      byt[op_q] <= byt[op_q] + BYTES_W'(push_size);
    end else if (pop_ok) begin
      hd[op_q]  <= pop_next;
      cnt[op_q] <= cnt[op_q] - 1'b1;
      byt[op_q] <= byt[op_q] - BYTES_W'(pop_size);
    end
  end

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && op_empty) |=> (cnt[$past(op_q)] == '0 && byt[$past(op_q)] == '0));
  p_push_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (cnt[$past(op_q)] == CW'($past(cnt[op_q]) + 1)));
  p_count_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cnt <= CW'(NODES));
endmodule

// File: rtl/dq_manager.sv
module dq_manager
  import dqm_pkg::*;
#(
  parameter int NQ      = 8,
  parameter int NODES   = 16,
  parameter int SIZE_W  = 16,
  parameter int BYTES_W = 24,
  localparam int QW     = $clog2(NQ),
  localparam int AW     = QW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:2] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          ovf_flag
);
  localparam int PW = $clog2(NODES);
  localparam int CW = $clog2(NODES + 1);

  word_e              req_word;
  logic [QW-1:0]      req_q;
  logic               op_push, op_pop, op_head, op_empty, push_ok, sel_empty;
  logic [QW-1:0]      op_q;
  logic [31:0]        op_desc, peek_desc, rdata;
  logic [SIZE_W-1:0]  op_size, pop_size, peek_size;
  logic [PW-1:0]      op_head_node, op_tail_node, new_node, pop_next, sel_head_node;
  logic [CW-1:0]      sel_cnt;
  logic [BYTES_W-1:0] sel_bytes;

  assign req_word = word_e'(req_addr[3:2]);
  assign req_q    = req_addr[AW-1:4];

  qm_mailbox #(.QW(QW), .SIZE_W(SIZE_W)) u_mbox (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_q(req_q), .req_word(req_word), .req_wdata(req_wdata), .req_ready(req_ready),
    .op_push(op_push), .op_pop(op_pop), .op_q(op_q), .op_desc(op_desc),
    .op_size(op_size), .op_head(op_head)
  );

  qm_store #(.NODES(NODES), .SIZE_W(SIZE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .do_push(op_push),
    .link_tail(!op_empty && !op_head), .tail_node(op_tail_node),
    .link_head(!op_empty && op_head), .head_node(op_head_node),
    .desc(op_desc), .size(op_size), .do_pop(op_pop && !op_empty),
    .pop_node(op_head_node), .peek_node(sel_head_node),
    .push_ok(push_ok), .new_node(new_node), .pop_next(pop_next), .pop_size(pop_size),
    .peek_desc(peek_desc), .peek_size(peek_size), .ovf(ovf_flag)
  );

  qm_qstate #(.NQ(NQ), .NODES(NODES), .SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_qstate (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .push_ok(push_ok), .push_head(op_head),
    .new_node(new_node), .push_size(op_size), .pop_req(op_pop), .pop_next(pop_next),
    .pop_size(pop_size), .sel_q(req_q), .op_empty(op_empty),
    .op_head_node(op_head_node), .op_tail_node(op_tail_node), .sel_cnt(sel_cnt),
    .sel_bytes(sel_bytes), .sel_head_node(sel_head_node), .sel_empty(sel_empty)
  );

  always_comb begin
    unique case (req_word)
      W_COUNT: rdata = 32'(sel_cnt);
      W_BYTES: rdata = 32'(sel_bytes);
      W_CTRL:  rdata = sel_empty ? 32'd0 : 32'(peek_size);
      W_DESC:  rdata = sel_empty ? 32'd0 : peek_desc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && req_ready && !req_write;
      if (req_valid && req_ready && !req_write) rsp_data <= rdata;
    end
  end

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_push && op_pop));
endmodule

// File: tb/sim_dq_manager.sv
module sim_dq_manager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, ovf_flag;
  logic [31:0] rsp_data;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dq_manager u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(addr[6:2]), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic        wr;
    logic        chk;
    logic [6:0]  ad;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  // byte address = queue*16 + word*4 (R1)
  localparam vec_t VT [21] = '{
    '{1'b0, 1'b1, 7'h00, 32'h0,         32'd0,      4'd2 },  // R2 empty count
    '{1'b1, 1'b0, 7'h08, 32'h40,        32'd0,      4'd4 },  // size 64, tail
    '{1'b1, 1'b0, 7'h0C, 32'h1000,      32'd0,      4'd5 },
    '{1'b1, 1'b0, 7'h08, 32'h20,        32'd0,      4'd4 },  // size 32
    '{1'b1, 1'b0, 7'h0C, 32'h2000,      32'd0,      4'd5 },
    '{1'b1, 1'b0, 7'h1C, 32'h3000,      32'd0,      4'd5 },  // q1, size 0
    '{1'b0, 1'b1, 7'h00, 32'h0,         32'd2,      4'd2 },
    '{1'b0, 1'b1, 7'h04, 32'h0,         32'd96,     4'd3 },  // R3
    '{1'b1, 1'b0, 7'h08, 32'h8000_0010, 32'd0,      4'd4 },  // breaks read: implied pop (R10)
    '{1'b1, 1'b0, 7'h0C, 32'h500,       32'd0,      4'd5 },  // head push
    '{1'b0, 1'b1, 7'h00, 32'h0,         32'd2,      4'd10},  // R10 one removed
    '{1'b0, 1'b1, 7'h08, 32'h0,         32'd16,     4'd6 },  // R6 head size
    '{1'b0, 1'b1, 7'h0C, 32'h0,         32'h500,    4'd5 },  // R5 head override
    '{1'b0, 1'b1, 7'h04, 32'h0,         32'd32,     4'd3 },
    '{1'b0, 1'b1, 7'h08, 32'h0,         32'd32,     4'd6 },
    '{1'b0, 1'b1, 7'h0C, 32'h0,         32'h2000,   4'd5 },
    '{1'b0, 1'b1, 7'h0C, 32'h0,         32'd0,      4'd7 },  // R7 empty pop
    '{1'b0, 1'b1, 7'h00, 32'h0,         32'd0,      4'd7 },
    '{1'b0, 1'b1, 7'h04, 32'h0,         32'd0,      4'd7 },
    '{1'b0, 1'b1, 7'h10, 32'h0,         32'd1,      4'd2 },  // implied pop of empty q0
    '{1'b0, 1'b1, 7'h1C, 32'h0,         32'h3000,   4'd6 }   // R6 pop returns address
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; addr = a; req_wdata = d; stalls = 0;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_data;
    if (!wr) check("R12 rsp_valid", 32'(rsp_valid), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset ready", 32'(req_ready), 32'd1);
    check("R12 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R8 reset ovf", 32'(ovf_flag), 32'd0);

    for (int i = 0; i < 21; i++) begin
      access(VT[i].wr, VT[i].ad, VT[i].d, rd, st);
      if (VT[i].chk) check($sformatf("R%0d vec %0d", VT[i].r, i), rd, VT[i].e);
    end

    // R9 broken write: stage size 7 on q2, then write word 0 of q3 (R11)
    access(1'b1, 7'h28, 32'd7, rd, st);
    access(1'b1, 7'h30, 32'hFFFF, rd, st);
    check("R9 stall cycles", 32'(st), 32'd1);
    access(1'b0, 7'h20, 32'h0, rd, st);       // q3 implied push runs first
    check("R9 stall on read", 32'(st), 32'd1);
    check("R9 implied push count", rd, 32'd1);
    access(1'b0, 7'h24, 32'h0, rd, st);
    check("R9 staged size kept", rd, 32'd7);
    access(1'b0, 7'h2C, 32'h0, rd, st);
    check("R9 descriptor zero", rd, 32'd0);
    access(1'b0, 7'h30, 32'h0, rd, st);
    check("R11 count not written", rd, 32'd1);
    access(1'b0, 7'h34, 32'h0, rd, st);
    check("R11 bytes not written", rd, 32'd0);
    access(1'b0, 7'h3C, 32'h0, rd, st);

    // R8 fill the pool on q4
    for (int i = 0; i < 16; i++) access(1'b1, 7'h4C, 32'h100 + i, rd, st);
    check("R8 no ovf at limit", 32'(ovf_flag), 32'd0);
    access(1'b1, 7'h4C, 32'hDEAD, rd, st);
    check("R8 ovf raised", 32'(ovf_flag), 32'd1);
    access(1'b0, 7'h40, 32'h0, rd, st);
    check("R8 dropped push", rd, 32'd16);
    access(1'b0, 7'h4C, 32'h0, rd, st);
    check("R5 fifo first", rd, 32'h100);
    for (int i = 1; i < 16; i++) begin
      access(1'b0, 7'h4C, 32'h0, rd, st);
      check("R5 fifo order", rd, 32'h100 + i);
    end

    // R13 recycled nodes fill q5 again, size 2 each
    for (int i = 0; i < 16; i++) begin
      access(1'b1, 7'h58, 32'd2, rd, st);
      access(1'b1, 7'h5C, 32'h200 + i, rd, st);
    end
    access(1'b0, 7'h54, 32'h0, rd, st);
    check("R13 bytes after reuse", rd, 32'd32);
    access(1'b0, 7'h5C, 32'h0, rd, st);
    check("R13 reuse head", rd, 32'h200);
    check("R8 ovf sticky", 32'(ovf_flag), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule